// File: doc/BRIEF.md
# Two-Level Fast/Normal Interrupt Controller

This block gathers up to a parameterised number of level-sensitive interrupt lines, one per peripheral module. Each line passes through a software-written enable bit and is then steered, by its own steering bit, to one of two request outputs. The fast request has the higher priority and may preempt a handler already running on the normal request. Arbitration between the two is left to the processor. Here both requests may be high together.

Software reads a pending word that has one bit per module. That bit tells the handler which module needs service. The handler then asks that module's own status for the exact event; no event detail is kept here. Three more views can be read: the raw line state, the fast-steered enabled lines and the normal-steered enabled lines. A wake output goes high whenever any enabled line is active, whatever its steering, so that power management can leave idle on any enabled interrupt, timers included.

All three outputs are registered, and so is the read data. Each of them reflects the inputs and register state that were present before the clock edge that loads it.

Top module: `icu_two_level`

## Requirements
- R1: A synchronous active-high reset clears the enable word, the steering word, both requests, wake and read data to zero.
- R2: A write to address 1 loads the enable word. A read of address 1 returns it.
- R3: A write to address 2 loads the steering word, in which bit value 1 selects the fast request. A read of address 2 returns it.
- R4: A read of address 0 returns the raw source lines, whatever the enable word holds.
- R5: A read of address 3 returns raw AND enable AND steering.
- R6: A read of address 4 returns raw AND enable AND NOT steering.
- R7: `fiq_req` is the OR of all bits of the fast pending view, registered for one cycle.
- R8: `irq_req` is the OR of all bits of the normal pending view, registered for one cycle.
- R9: `wake` is the OR of all bits of raw AND enable, registered for one cycle, and it does not depend on steering.
- R10: Writes to addresses 0, 3, 4, 5, 6 and 7 change no state. Reads of addresses 5 to 7 return zero.
- R11: Read data is registered. It shows, one cycle later, the value of the word that was addressed before the clock edge, including the state from before any write made on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Level-sensitive interrupt lines, one per module |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for both reads and writes |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Registered read data |
| fiq_req_o | output | 1 | Fast interrupt request |
| irq_req_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Any enabled source is active |

## Verification
The bench moves the steering bit of a single active source back and forth. A design with an inverted or swapped steering polarity would raise the wrong request. It also keeps sources active while their enable bits are clear. A design that gated only one path, or took wake from the raw lines, would wake or raise a request too early. Writes aimed at the read-only views and the unused addresses would corrupt the enable or steering word if the address decode were partial. A write followed by a read on the same edge tells a read-before-write mux from a read-after-write one. The bench also runs long random sequences of source patterns and register operations, and compares every output on every cycle against a behavioural model.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int ICU_ADDR_W = 3;

  typedef enum logic [ICU_ADDR_W-1:0] {
    ICU_RAW   = 3'd0,
    ICU_EN    = 3'd1,
    ICU_STEER = 3'd2,
    ICU_FPEND = 3'd3,
    ICU_NPEND = 3'd4
  } icu_addr_e;
endpackage

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic [ICU_ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]      wdata_i,
  output logic [N_SRC-1:0]      en_o,
  output logic [N_SRC-1:0]      steer_o
);
  logic wr_en_sel, wr_steer_sel;

  always_comb begin
    wr_en_sel    = wr_i && (addr_i == ICU_EN);
    wr_steer_sel = wr_i && (addr_i == ICU_STEER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= '0;
      steer_o <= '0;
    end else begin
      if (wr_en_sel)    en_o    <= wdata_i;
      if (wr_steer_sel) steer_o <= wdata_i;
    end
  end

  // R1: reset leaves both words cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (en_o == '0) && (steer_o == '0));

  // R2: an enable write lands on the next cycle
  p_en_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ICU_EN) |=> en_o == $past(wdata_i));

  // R10: a write to the raw view or the pending views disturbs nothing
  p_ro_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (addr_i == ICU_RAW || addr_i == ICU_FPEND || addr_i == ICU_NPEND))
      |=> $stable(en_o) && $stable(steer_o));
endmodule

// File: rtl/icu_route.sv
module icu_route #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] steer_i,
  output logic [N_SRC-1:0] fpend_o,
  output logic [N_SRC-1:0] npend_o,
  output logic             fiq_req_o,
  output logic             irq_req_o,
  output logic             wake_o
);
  logic [N_SRC-1:0] live;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_comb begin
      live[g]    = raw_i[g] & en_i[g];
      fpend_o[g] = live[g] & steer_i[g];
      npend_o[g] = live[g] & ~steer_i[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_req_o <= 1'b0;
      irq_req_o <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      fiq_req_o <= |fpend_o;
      irq_req_o <= |npend_o;
      wake_o    <= |live;
    end
  end

  // R9: every request implies wake
  p_fiq_wakes_r9: assert property (@(posedge clk) disable iff (rst)
    fiq_req_o |-> wake_o);
  p_irq_wakes_r9: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> wake_o);
  // R7 R8: an enabled active source always reaches one of the two requests
  p_wake_routed_r7: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (fiq_req_o || irq_req_o));
  // R7: the fast request follows the inputs from one cycle earlier
  p_fiq_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (|(raw_i & en_i & steer_i)) |=> fiq_req_o);
endmodule

// File: rtl/icu_readmux.sv
module icu_readmux
  import icu_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ICU_ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]      raw_i,
  input  logic [N_SRC-1:0]      en_i,
  input  logic [N_SRC-1:0]      steer_i,
  input  logic [N_SRC-1:0]      fpend_i,
  input  logic [N_SRC-1:0]      npend_i,
  output logic [N_SRC-1:0]      rdata_o
);
  logic [N_SRC-1:0] sel;

  always_comb begin
    unique case (addr_i)
      ICU_RAW:   sel = raw_i;
      ICU_EN:    sel = en_i;
      ICU_STEER: sel = steer_i;
      ICU_FPEND: sel = fpend_i;
      ICU_NPEND: sel = npend_i;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= sel;
  end

  // R10: addresses 5 to 7 read back zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (addr_i > 3'd4) |=> rdata_o == '0);
endmodule

// File: rtl/icu_two_level.sv
module icu_two_level
  import icu_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SRC-1:0]      src_i,
  input  logic                  reg_wr_i,
  input  logic [ICU_ADDR_W-1:0] reg_addr_i,
  input  logic [N_SRC-1:0]      reg_wdata_i,
  output logic [N_SRC-1:0]      reg_rdata_o,
  output logic                  fiq_req_o,
  output logic                  irq_req_o,
  output logic                  wake_o
);
  logic [N_SRC-1:0] en_w, steer_w, fpend_w, npend_w;

  icu_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .en_o(en_w), .steer_o(steer_w)
  );

  icu_route #(.N_SRC(N_SRC)) u_route (
    .clk(clk), .rst(rst), .raw_i(src_i), .en_i(en_w), .steer_i(steer_w),
    .fpend_o(fpend_w), .npend_o(npend_w),
    .fiq_req_o(fiq_req_o), .irq_req_o(irq_req_o), .wake_o(wake_o)
  );

  icu_readmux #(.N_SRC(N_SRC)) u_rd (
    .clk(clk), .rst(rst), .addr_i(reg_addr_i), .raw_i(src_i),
    .en_i(en_w), .steer_i(steer_w), .fpend_i(fpend_w), .npend_i(npend_w),
    .rdata_o(reg_rdata_o)
  );

  // R8: the normal request cannot appear without an enabled active line one cycle earlier
  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_req_o) && !$past(rst)) |-> $past(|(src_i & en_w)));
endmodule

// File: tb/icu_two_level_tb_top.sv
module icu_two_level_tb_top;
  localparam int N = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst;
  logic [N-1:0] src;
  logic         wr;
  logic [2:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic         fiq, irq, wake;

  icu_two_level #(.N_SRC(N)) dut_i (
    .clk(clk), .rst(rst), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fiq_req_o(fiq), .irq_req_o(irq), .wake_o(wake)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] m_en = '0, m_steer = '0;
  logic [N-1:0] e_rd = '0;
  logic e_fiq = 0, e_irq = 0, e_wake = 0;
  string rd_tag = "R1";

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [N-1:0] on;
    @(posedge clk);
    on = src & m_en;
    if (rst) begin
      e_fiq = 0; e_irq = 0; e_wake = 0; e_rd = '0;
      m_en = '0; m_steer = '0; rd_tag = "R1";
    end else begin
      e_fiq  = |(on & m_steer);
      e_irq  = |(on & ~m_steer);
      e_wake = |on;
      case (addr)
        3'd0: begin e_rd = src;             rd_tag = "R4"; end
        3'd1: begin e_rd = m_en;            rd_tag = "R2"; end
        3'd2: begin e_rd = m_steer;         rd_tag = "R3"; end
        3'd3: begin e_rd = on & m_steer;    rd_tag = "R5"; end
        3'd4: begin e_rd = on & ~m_steer;   rd_tag = "R6"; end
        default: begin e_rd = '0;           rd_tag = "R10"; end
      endcase
      if (wr && addr == 3'd1) m_en = wdata;
      if (wr && addr == 3'd2) m_steer = wdata;
    end
    @(negedge clk);
    chk("R7 fiq_req", {{(N-1){1'b0}}, fiq}, {{(N-1){1'b0}}, e_fiq});
    chk("R8 irq_req", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, e_irq});
    chk("R9 wake",    {{(N-1){1'b0}}, wake}, {{(N-1){1'b0}}, e_wake});
    chk({rd_tag, " R11 rdata"}, rdata, e_rd);
  endtask

  task automatic op(logic w, logic [2:0] a, logic [N-1:0] d, logic [N-1:0] s);
    wr = w; addr = a; wdata = d; src = s;
    tick();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<100000", wd);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst = 1; src = '1; wr = 0; addr = 0; wdata = '0;
    repeat (3) tick();
    rst = 0;
    // R1: after reset, active lines with a cleared enable word raise nothing
    op(0, 3'd1, '0, '1);
    op(0, 3'd2, '0, '1);
    op(0, 3'd0, '0, 32'hA5A5_0001);      // R4 raw view while nothing is enabled
    // R2 R3: load enable and steering, then read each back
    op(1, 3'd1, 32'hFFFF_0000, 32'h0000_FFFF);
    op(1, 3'd2, 32'hFF00_FF00, 32'h0000_FFFF);
    op(0, 3'd1, '0, 32'h0000_FFFF);       // R9 no wake, since the enabled bits are idle
    op(0, 3'd2, '0, 32'h0100_0000);
    op(0, 3'd3, '0, 32'h0001_0000);       // R6 normal path only
    op(0, 3'd4, '0, 32'h0001_0000);
    // R3: a single source steered fast, then normal
    op(1, 3'd2, 32'h8000_0000, 32'h8000_0000);
    op(0, 3'd3, '0, 32'h8000_0000);
    op(1, 3'd2, 32'h0000_0000, 32'h8000_0000);
    op(0, 3'd4, '0, 32'h8000_0000);
    // R11: a write and a read on the same edge return the old word
    op(1, 3'd1, 32'h1234_5678, 32'h8000_0000);
    op(0, 3'd1, '0, 32'h8000_0000);
    // R10: writes to read-only and unused addresses are dropped
    for (int a = 0; a < 8; a++) begin
      if (a != 1 && a != 2) op(1, a[2:0], 32'hDEAD_BEEF, 32'h0F0F_0F0F);
    end
    op(0, 3'd1, '0, '0);
    op(0, 3'd2, '0, '0);
    for (int a = 5; a < 8; a++) op(0, a[2:0], '0, '1);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      op(($urandom % 4) == 0, 3'($urandom % 8), $urandom, $urandom & $urandom);
    end
    // R1: reset in mid-run clears everything
    rst = 1; tick(); rst = 0;
    op(0, 3'd1, '0, '1);
    op(0, 3'd2, '0, '1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule